// File: doc/BRIEF.md
# Dual-Clock Block RAM with Read Enable and Address Hold

A simple dual-port synchronous memory with two independent clocks. The write side stores one word per write-clock edge while its write enable is high. The read side owns a registered data output that is updated only on read-clock edges where the read enable is high.

When the read enable is low, the read port captures no address and performs no memory access. The output then keeps the word from the most recent enabled read, even if that location is rewritten meanwhile.

An address-hold input makes an enabled read reuse the address captured by the previous enabled read, whatever the address bus carries. A parameter picks what an enabled read returns when, on a shared clock edge, it hits the location being written: the old word, the new word, or an unspecified value.

Top module: `dc_ram_rden`

## Requirements
- R1: A write-clock rising edge with `wr_en` high stores `wr_data` at `wr_addr`. Memory contents are never changed by the read side or by read-side reset.
- R2: A read-clock rising edge with `rd_en` high and `rd_hold` low captures `rd_addr`. After that same edge, `rd_data` shows the word stored at that address (one edge of latency).
- R3: A read-clock edge with `rd_en` low captures no address and leaves `rd_data` unchanged, even when `rd_addr` differs from the last captured address.
- R4: A read-clock edge with `rd_en` high and `rd_hold` high reads from the previously captured address, whatever the value on `rd_addr`, and keeps that address captured.
- R5: Writes performed while `rd_en` is low, including writes to the last-read location, do not change `rd_data`. A later enabled read of that location returns the new word.
- R6: With `RDW_MODE` = 0 (old data) and both ports on one clock, an enabled read of the address being written on the same edge returns the word stored before that write.
- R7: With `RDW_MODE` = 1 (new data) and both ports on one clock, an enabled read of the address being written on the same edge returns the incoming `wr_data`. `RDW_MODE` = 2 leaves the value unspecified.
- R8: Asserting `rd_rst_n` low clears `rd_data` and the captured read address to zero without altering memory. An enabled held read right after reset therefore returns the word at address 0.
- R9: While `rd_en` is low, `rd_hold` has no effect: the output holds, and the next enabled read with `rd_hold` low uses `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset of the read register and captured address |
| rd_en | input | 1 | Read enable |
| rd_hold | input | 1 | Reuse the previously captured read address |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | DATA_W | Registered read word |

## Verification
Every enabled read produces its word on the same read-clock edge that captures the address. The bench therefore drives read inputs on a falling edge and compares `rd_data` at the next falling edge, half a period after the capturing edge. Writes land on the write-clock edge following their setup, and the bench waits for that edge before any dependent read. The hold cases (R3, R5, R9) are compared one falling edge after the non-reading stimulus, against a reference array and a modelled captured address. The same-edge collision cases use two extra instances that share one clock, and are sampled at the falling edge after the shared rising edge.

// File: rtl/dc_ram_rden.sv
module dc_ram_rden #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 32,
  parameter int RDW_MODE = 0,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic              rd_hold,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] cap_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] rd_word;

  // R1: write port
  always_ff @(posedge wr_clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  // R4: hold reuses the captured address
  assign eff_addr = rd_hold ? cap_addr : rd_addr;

  generate
    if (RDW_MODE == 1) begin : g_new_data
      logic wr_hit;
      // R7: forward the incoming word on a same-edge collision
      assign wr_hit  = wr_en && (wr_addr == eff_addr);
      assign rd_word = wr_hit ? wr_data : mem[eff_addr];
    end else begin : g_old_data
      // R6: array read sees the pre-write word; mode 2 returns the same
      assign rd_word = mem[eff_addr];
    end
  endgenerate

  // R2, R3, R8: read register and captured address
  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      cap_addr <= '0;
      rd_data  <= '0;
    end else if (rd_en) begin
      cap_addr <= eff_addr;
      rd_data  <= rd_word;
    end

  p_hold_out_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_data));

  p_hold_addr_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(cap_addr));

  p_stall_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_hold) |=> $stable(cap_addr));

  p_capture_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !rd_hold) |=> cap_addr == $past(rd_addr));

  p_reset_clear_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(rd_rst_n) |-> (rd_data == '0 && cap_addr == '0));

endmodule

// File: tb/dc_ram_rden_tb.sv
module dc_ram_rden_tb;
  localparam int DW = 16;
  localparam int DP = 32;
  localparam int AW = $clog2(DP);

  logic clk = 1'b0, wclk = 1'b0;
  always #2 clk = ~clk;
  always #3.5 wclk = ~wclk;

  logic rst_n = 1'b0;
  logic wen = 1'b0, ren = 1'b0, hold = 1'b0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0, rdata;

  logic s_wen = 1'b0, s_ren = 1'b0;
  logic [AW-1:0] s_waddr = '0, s_raddr = '0;
  logic [DW-1:0] s_wdata = '0, old_q, new_q;

  dc_ram_rden #(.DATA_W(DW), .DEPTH(DP), .RDW_MODE(0)) u_dut (
    .wr_clk(wclk), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(ren), .rd_hold(hold),
    .rd_addr(raddr), .rd_data(rdata));

  dc_ram_rden #(.DATA_W(DW), .DEPTH(DP), .RDW_MODE(0)) u_old (
    .wr_clk(clk), .wr_en(s_wen), .wr_addr(s_waddr), .wr_data(s_wdata),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(s_ren), .rd_hold(1'b0),
    .rd_addr(s_raddr), .rd_data(old_q));

  dc_ram_rden #(.DATA_W(DW), .DEPTH(DP), .RDW_MODE(1)) u_new (
    .wr_clk(clk), .wr_en(s_wen), .wr_addr(s_waddr), .wr_data(s_wdata),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(s_ren), .rd_hold(1'b0),
    .rd_addr(s_raddr), .rd_data(new_q));

  int total = 0, bad = 0;
  logic [DW-1:0] ref_mem [DP];
  logic [AW-1:0] m_cap = '0;
  logic [DW-1:0] m_out = '0;

  // {rd_en, rd_hold, rd_addr}
  localparam logic [AW+1:0] VEC [14] = '{
    {2'b10, 5'd3},   // R2
    {2'b10, 5'd17},  // R2
    {2'b00, 5'd9},   // R3 address moves, no read
    {2'b01, 5'd22},  // R9 hold ignored while disabled
    {2'b00, 5'd1},   // R3
    {2'b11, 5'd30},  // R4 stall: reuse 17
    {2'b11, 5'd0},   // R4
    {2'b10, 5'd31},  // R2 top address
    {2'b10, 5'd0},   // R2 bottom address
    {2'b01, 5'd12},  // R9
    {2'b10, 5'd12},  // R9 next enabled read uses bus
    {2'b11, 5'd5},   // R4
    {2'b10, 5'd8},   // R2
    {2'b00, 5'd8}    // R3
  };

  function automatic logic [DW-1:0] pat(input int a);
    return 16'hA500 ^ DW'(a * 263);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_main(input int a, input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1; waddr = AW'(a); wdata = d;
    @(negedge wclk);
    wen = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic rd_step(input logic e, input logic h, input logic [AW-1:0] a);
    @(negedge clk);
    ren = e; hold = h; raddr = a;
    if (e) begin
      if (!h) m_cap = a;
      m_out = ref_mem[m_cap];
    end
    @(negedge clk);
    ren = 1'b0; hold = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset output", rdata, '0);
    rst_n = 1'b1;

    for (int i = 0; i < DP; i++) wr_main(i, pat(i));
    @(negedge clk);
    check("R5 writes with rd_en low", rdata, '0);

    foreach (VEC[k]) begin
      rd_step(VEC[k][AW+1], VEC[k][AW], VEC[k][AW-1:0]);
      check("R2/R3/R4/R9 table", rdata, m_out);
    end

    // R5: rewrite the last-read location while reads are off
    rd_step(1'b1, 1'b0, 5'd6);
    check("R2 read before rewrite", rdata, pat(6));
    wr_main(6, 16'h1234);
    repeat (2) @(negedge clk);
    check("R5 output unchanged by write", rdata, pat(6));
    rd_step(1'b1, 1'b1, 5'd20);
    check("R5 new word after enabled read", rdata, 16'h1234);
    check("R1 stored word", rdata, ref_mem[6]);

    // R8: reset mid-run keeps memory, clears captured address
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 output cleared", rdata, '0);
    rst_n = 1'b1;
    m_cap = '0;
    rd_step(1'b1, 1'b1, 5'd19);
    check("R8 held read uses address 0", rdata, pat(0));

    // R6/R7: same-edge collision on shared-clock instances
    @(negedge clk);
    s_wen = 1'b1; s_waddr = 5'd5; s_wdata = 16'hAAAA;
    @(negedge clk);
    s_wen = 1'b1; s_waddr = 5'd5; s_wdata = 16'h5555;
    s_ren = 1'b1; s_raddr = 5'd5;
    @(negedge clk);
    s_wen = 1'b0; s_ren = 1'b0;
    check("R6 old data on collision", old_q, 16'hAAAA);
    check("R7 new data on collision", new_q, 16'h5555);
    @(negedge clk);
    s_ren = 1'b1;
    @(negedge clk);
    s_ren = 1'b0;
    check("R6 later read sees write", old_q, 16'h5555);
    check("R7 later read sees write", new_q, 16'h5555);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule